// File: doc/BRIEF.md
# Processor Special Cycle Responder

This block sits next to the second-level cache controller. It watches for processor special bus cycles and carries out the action each one needs. Each special cycle arrives as a one-cycle strobe with an encoded type.

Both cache-flush variants start one full walk of the cache flush sequencer. The processor is told the cycle is done only when that walk reports completion. A write-back cycle needs no cache work, because the flush that follows it cleans every modified line, so it is acknowledged at once.

Halt and stop-grant cycles first take the cache SRAMs into low-power standby, if a configuration enable allows it. One cycle later the block raises a special-cycle request of the same kind toward the peripheral bus. The processor gets its ready once the peripheral side acknowledges that request. The SRAMs are selected again on the next ordinary processor memory access.

Top module: `spc_responder`

## Requirements
- R1: After reset, cpu_ready, flush_start, pbus_req and sram_standby are low and sram_cs is high.
- R2: A strobe of type code 1 (write-back) raises cpu_ready for exactly one cycle, in the cycle after the sampling edge. It pulses no flush_start, raises no pbus_req and leaves sram_standby as it was.
- R3: A strobe of type code 0 (flush) or code 2 (flush acknowledge) raises flush_start for exactly one cycle, in the cycle after the sampling edge.
- R4: For a flush-type cycle, cpu_ready stays low until flush_done is sampled high. It then pulses for one cycle, in the cycle after that edge.
- R5: With cfg_standby_en high, a strobe of code 3 (halt) or code 4 (stop grant) sets sram_standby high and sram_cs low in the cycle after the sampling edge. pbus_req rises one cycle after that.
- R6: pbus_type is 0 for a forwarded halt and 1 for a forwarded stop grant. pbus_req and pbus_type hold steady until pbus_ack is sampled.
- R7: For halt and stop grant, cpu_ready pulses for one cycle in the cycle after pbus_ack is sampled, and pbus_req falls in that same cycle.
- R8: With cfg_standby_en low, halt and stop grant leave sram_standby low and sram_cs high, and are still forwarded with the same timing.
- R9: While in standby, a mem_access pulse clears sram_standby and sets sram_cs in the cycle after it is sampled.
- R10: Type codes 5, 6 and 7 pulse cpu_ready one cycle after the sampling edge, with no other output changing.
- R11: A strobe that arrives while a flush or a forwarded cycle is still outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_standby_en | input | 1 | Allows SRAM standby on power-state cycles |
| sc_valid | input | 1 | Special-cycle strobe, one cycle |
| sc_type | input | TYPE_W | Encoded special-cycle type |
| mem_access | input | 1 | Ordinary processor memory access pulse |
| flush_start | output | 1 | Starts the cache flush walk (one-cycle pulse) |
| flush_done | input | 1 | Flush walk finished |
| sram_cs | output | 1 | Cache SRAM chip select, active high |
| sram_standby | output | 1 | Cache SRAM low-power standby |
| pbus_req | output | 1 | Peripheral-bus special-cycle request |
| pbus_type | output | PB_W | Kind of forwarded cycle |
| pbus_ack | input | 1 | Peripheral bus accepted the request |
| cpu_ready | output | 1 | Ready back to the processor (one-cycle pulse) |

## Verification
Every result is due a fixed number of edges after the stimulus that causes it. Ready for write-back and unknown codes, flush_start, the standby change and the reselect after an access all appear one edge after sampling. The peripheral request appears two edges after the strobe. Ready for flushes and power cycles appears one edge after flush_done or pbus_ack. The bench drives inputs on falling edges and samples outputs on the falling edge that follows the expected rising edge. In the cycles before that edge it also checks that the output is still low, so a response that comes early or late is caught.

// File: rtl/spc_pkg.sv
package spc_pkg;
  typedef enum logic [2:0] {
    K_FLUSH,
    K_WB,
    K_HALT,
    K_SGNT,
    K_OTHER
  } kind_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_FLUSH,
    S_FWD,
    S_PBUS
  } state_e;
endpackage

// File: rtl/spc_decode.sv
module spc_decode
  import spc_pkg::*;
#(
  parameter int TYPE_W     = 3,
  parameter int CODE_FLUSH = 0,
  parameter int CODE_WB    = 1,
  parameter int CODE_FACK  = 2,
  parameter int CODE_HALT  = 3,
  parameter int CODE_SGNT  = 4
) (
  input  logic [TYPE_W-1:0] sc_type,
  output kind_e             kind
);
  localparam logic [TYPE_W-1:0] C_FLUSH = TYPE_W'(CODE_FLUSH);
  localparam logic [TYPE_W-1:0] C_WB    = TYPE_W'(CODE_WB);
  localparam logic [TYPE_W-1:0] C_FACK  = TYPE_W'(CODE_FACK);
  localparam logic [TYPE_W-1:0] C_HALT  = TYPE_W'(CODE_HALT);
  localparam logic [TYPE_W-1:0] C_SGNT  = TYPE_W'(CODE_SGNT);

  always_comb begin
    if (sc_type == C_FLUSH || sc_type == C_FACK) kind = K_FLUSH;
    else if (sc_type == C_WB)                    kind = K_WB;
    else if (sc_type == C_HALT)                  kind = K_HALT;
    else if (sc_type == C_SGNT)                  kind = K_SGNT;
    else                                         kind = K_OTHER;
  end
endmodule

// File: rtl/spc_standby.sv
module spc_standby (
  input  logic clk,
  input  logic rst,
  input  logic enter,
  input  logic mem_access,
  output logic sram_standby,
  output logic sram_cs
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sram_standby <= 1'b0;
      sram_cs      <= 1'b1;
    end else if (enter) begin
      sram_standby <= 1'b1;
      sram_cs      <= 1'b0;
    end else if (mem_access) begin
      sram_standby <= 1'b0;
      sram_cs      <= 1'b1;
    end
  end
endmodule

// File: rtl/spc_seq.sv
module spc_seq
  import spc_pkg::*;
#(
  parameter int PB_W    = 2,
  parameter int PB_HALT = 0,
  parameter int PB_SGNT = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sc_valid,
  input  kind_e           kind,
  input  logic            cfg_standby_en,
  input  logic            flush_done,
  input  logic            pbus_ack,
  output logic            enter_standby,
  output logic            flush_start,
  output logic            cpu_ready,
  output logic            pbus_req,
  output logic [PB_W-1:0] pbus_type
);
  localparam logic [PB_W-1:0] T_HALT = PB_W'(PB_HALT);
  localparam logic [PB_W-1:0] T_SGNT = PB_W'(PB_SGNT);

  state_e          state;
  logic [PB_W-1:0] pend_type;
  logic            accept;
  logic            is_pwr;

  assign accept        = (state == S_IDLE) && sc_valid;
  assign is_pwr        = (kind == K_HALT) || (kind == K_SGNT);
  assign enter_standby = accept && is_pwr && cfg_standby_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      pend_type   <= '0;
      flush_start <= 1'b0;
      cpu_ready   <= 1'b0;
      pbus_req    <= 1'b0;
      pbus_type   <= '0;
    end else begin
      flush_start <= 1'b0;
      cpu_ready   <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (sc_valid) begin
            unique case (kind)
              K_FLUSH: begin
                flush_start <= 1'b1;
                state       <= S_FLUSH;
              end
              K_HALT: begin
                pend_type <= T_HALT;
                state     <= S_FWD;
              end
              K_SGNT: begin
                pend_type <= T_SGNT;
                state     <= S_FWD;
              end
              default: cpu_ready <= 1'b1;
            endcase
          end
        end
        S_FLUSH: begin
          if (flush_done) begin
            cpu_ready <= 1'b1;
            state     <= S_IDLE;
          end
        end
        S_FWD: begin
          pbus_req  <= 1'b1;
          pbus_type <= pend_type;
          state     <= S_PBUS;
        end
        S_PBUS: begin
          if (pbus_ack) begin
            pbus_req  <= 1'b0;
            cpu_ready <= 1'b1;
            state     <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spc_responder.sv
module spc_responder
  import spc_pkg::*;
#(
  parameter int TYPE_W     = 3,
  parameter int PB_W       = 2,
  parameter int CODE_FLUSH = 0,
  parameter int CODE_WB    = 1,
  parameter int CODE_FACK  = 2,
  parameter int CODE_HALT  = 3,
  parameter int CODE_SGNT  = 4,
  parameter int PB_HALT    = 0,
  parameter int PB_SGNT    = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_standby_en,
  input  logic              sc_valid,
  input  logic [TYPE_W-1:0] sc_type,
  input  logic              mem_access,
  output logic              flush_start,
  input  logic              flush_done,
  output logic              sram_cs,
  output logic              sram_standby,
  output logic              pbus_req,
  output logic [PB_W-1:0]   pbus_type,
  input  logic              pbus_ack,
  output logic              cpu_ready
);
  kind_e kind;
  logic  enter_standby;

  spc_decode #(
    .TYPE_W(TYPE_W), .CODE_FLUSH(CODE_FLUSH), .CODE_WB(CODE_WB),
    .CODE_FACK(CODE_FACK), .CODE_HALT(CODE_HALT), .CODE_SGNT(CODE_SGNT)
  ) u_decode (
    .sc_type(sc_type),
    .kind   (kind)
  );

  spc_seq #(
    .PB_W(PB_W), .PB_HALT(PB_HALT), .PB_SGNT(PB_SGNT)
  ) u_seq (
    .clk           (clk),
    .rst           (rst),
    .sc_valid      (sc_valid),
    .kind          (kind),
    .cfg_standby_en(cfg_standby_en),
    .flush_done    (flush_done),
    .pbus_ack      (pbus_ack),
    .enter_standby (enter_standby),
    .flush_start   (flush_start),
    .cpu_ready     (cpu_ready),
    .pbus_req      (pbus_req),
    .pbus_type     (pbus_type)
  );

  spc_standby u_standby (
    .clk         (clk),
    .rst         (rst),
    .enter       (enter_standby),
    .mem_access  (mem_access),
    .sram_standby(sram_standby),
    .sram_cs     (sram_cs)
  );
endmodule

// File: rtl/spc_responder_chk.sv
module spc_responder_chk #(
  parameter int PB_W = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            cfg_standby_en,
  input logic            flush_start,
  input logic            cpu_ready,
  input logic            pbus_req,
  input logic [PB_W-1:0] pbus_type,
  input logic            pbus_ack,
  input logic            sram_standby
);
  assert_flush_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    flush_start |=> !flush_start);

  assert_flush_not_ready_R4: assert property (@(posedge clk) disable iff (rst)
    flush_start |-> !cpu_ready);

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (pbus_req && !pbus_ack) |=> (pbus_req && $stable(pbus_type)));

  assert_ack_ready_R7: assert property (@(posedge clk) disable iff (rst)
    (pbus_req && pbus_ack) |=> (cpu_ready && !pbus_req));

  assert_standby_gated_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_standby) |-> $past(cfg_standby_en));

  assert_no_overlap_R11: assert property (@(posedge clk) disable iff (rst)
    !(flush_start && pbus_req));
endmodule

bind spc_responder spc_responder_chk #(.PB_W(PB_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cfg_standby_en(cfg_standby_en),
  .flush_start   (flush_start),
  .cpu_ready     (cpu_ready),
  .pbus_req      (pbus_req),
  .pbus_type     (pbus_type),
  .pbus_ack      (pbus_ack),
  .sram_standby  (sram_standby)
);

// File: tb/test_spc_responder.sv
module test_spc_responder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_standby_en = 1'b0;
  logic       sc_valid = 1'b0;
  logic [2:0] sc_type = '0;
  logic       mem_access = 1'b0;
  logic       flush_done = 1'b0;
  logic       pbus_ack = 1'b0;
  logic       flush_start, sram_cs, sram_standby, pbus_req, cpu_ready;
  logic [1:0] pbus_type;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  spc_responder i_spc_responder (
    .clk(clk), .rst(rst), .cfg_standby_en(cfg_standby_en),
    .sc_valid(sc_valid), .sc_type(sc_type), .mem_access(mem_access),
    .flush_start(flush_start), .flush_done(flush_done),
    .sram_cs(sram_cs), .sram_standby(sram_standby),
    .pbus_req(pbus_req), .pbus_type(pbus_type), .pbus_ack(pbus_ack),
    .cpu_ready(cpu_ready)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic strobe(input int code);
    sc_valid = 1'b1;
    sc_type  = 3'(code);
    @(negedge clk);
    sc_valid = 1'b0;
  endtask

  task automatic run_flush(input int code, input int d);
    strobe(code);
    check("R3 flush_start", flush_start, 1);
    check("R4 early ready", cpu_ready, 0);
    strobe(1);  // stray write-back while the walk is busy
    check("R3 one-cycle start", flush_start, 0);
    check("R11 stray ignored", cpu_ready, 0);
    for (int i = 0; i < d; i++) begin
      @(negedge clk);
      check("R4 waiting", cpu_ready, 0);
    end
    flush_done = 1'b1;
    @(negedge clk);
    flush_done = 1'b0;
    check("R4 ready after done", cpu_ready, 1);
    @(negedge clk);
    check("R4 one-cycle ready", cpu_ready, 0);
  endtask

  task automatic run_power(input int code, input int en, input int d);
    cfg_standby_en = en[0];
    strobe(code);
    check(en ? "R5 standby" : "R8 no standby", sram_standby, en);
    check(en ? "R5 deselect" : "R8 cs kept", sram_cs, 1 - en);
    check("R5 req not yet", pbus_req, 0);
    @(negedge clk);
    check("R5 req", pbus_req, 1);
    check("R6 type", pbus_type, code - 3);
    check("R7 early ready", cpu_ready, 0);
    for (int i = 0; i < d; i++) begin
      if (i == 0) sc_valid = 1'b1;  // stray strobe while forwarding
      sc_type = 3'd1;
      @(negedge clk);
      sc_valid = 1'b0;
      check("R6 req held", pbus_req, 1);
      check("R6 type held", pbus_type, code - 3);
      check("R11 stray ignored", cpu_ready, 0);
    end
    pbus_ack = 1'b1;
    @(negedge clk);
    pbus_ack = 1'b0;
    check("R7 ready", cpu_ready, 1);
    check("R7 req drop", pbus_req, 0);
    @(negedge clk);
    check("R7 one-cycle ready", cpu_ready, 0);
    strobe(1);
    check("R2 wb ready", cpu_ready, 1);
    check("R2 standby kept", sram_standby, en);
    check("R2 no flush", flush_start, 0);
    mem_access = 1'b1;
    @(negedge clk);
    mem_access = 1'b0;
    check("R9 standby cleared", sram_standby, 0);
    check("R9 reselected", sram_cs, 1);
    check("R2 one-cycle ready", cpu_ready, 0);
  endtask

  task automatic run_simple(input int code);
    strobe(code);
    check(code == 1 ? "R2 ready" : "R10 ready", cpu_ready, 1);
    check(code == 1 ? "R2 no flush" : "R10 no flush", flush_start, 0);
    check(code == 1 ? "R2 no req" : "R10 no req", pbus_req, 0);
    check(code == 1 ? "R2 standby" : "R10 standby", sram_standby, 0);
    @(negedge clk);
    check(code == 1 ? "R2 pulse" : "R10 pulse", cpu_ready, 0);
    check("R10 still no req", pbus_req, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 ready", cpu_ready, 0);
    check("R1 flush_start", flush_start, 0);
    check("R1 req", pbus_req, 0);
    check("R1 standby", sram_standby, 0);
    check("R1 cs", sram_cs, 1);
    for (int en = 0; en < 2; en++) begin
      for (int code = 0; code < 8; code++) begin
        for (int d = 0; d < 3; d++) begin
          if (code == 0 || code == 2) run_flush(code, d);
          else if (code == 3 || code == 4) run_power(code, en, d);
          else run_simple(code);
          @(negedge clk);
        end
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule